// File: doc/BRIEF.md
# Row Histogram Accumulator With Total

This block takes a binary pixel stream that arrives several pixels per clock, all pixels of a cycle lying on the same window row, and keeps one count of active pixels per row in a small dual-port memory. Each accepted batch is counted and added to its row's entry through a two-stage read-modify-write pipeline. A write-back bypass makes back-to-back batches on one row add up correctly. A separate register keeps the running total of active pixels across the whole window. A downstream median search can use this total as its threshold.

Before each window, a clear sweep writes zero to every row word and resets the total. When no batch is offered, the row memory can be read through a readout port, with a one-cycle latency.

Top module: `row_hist_accum`

## Requirements
- R1: After reset `clr_busy` is 0 and `total` is 0.
- R2: A batch accepted with `pix_valid`=1 on row `row_idx` adds the number of set bits of `pix` (bit i is lane i, 1 = active) to that row's count. Other rows keep their counts.
- R3: Batches on consecutive cycles that hit the same row are all counted, with no increment lost. Batches that alternate between rows are also all counted.
- R4: A batch with `pix`=0 changes neither its row's count nor `total`.
- R5: `total` equals the sum of the set-bit counts of all batches accepted since the last clear. It is updated on the clock edge that accepts the batch.
- R6: A `clr_go` pulse while idle raises `clr_busy` from the next edge, for exactly WIN_H cycles. Afterwards every row reads 0.
- R7: On the edge that takes `clr_go`, `total` becomes 0. A batch offered in the `clr_go` cycle or while `clr_busy` is 1 is ignored.
- R8: In a cycle with `pix_valid`=0, `rd_row` selects a row, and `rd_count` shows its count after the next edge. This includes an update that is written on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_go | input | 1 | Start a clear sweep of the row memory and the total |
| clr_busy | output | 1 | Clear sweep in progress; input batches ignored |
| pix_valid | input | 1 | A pixel batch is offered this cycle |
| pix | input | LANES | Binary pixels of the batch, bit i is lane i |
| row_idx | input | $clog2(WIN_H) | Row of the offered batch |
| rd_row | input | $clog2(WIN_H) | Row to read out when no batch is offered |
| rd_count | output | $clog2(WIN_W)+1 | Count of the row selected one cycle earlier |
| total | output | $clog2(WIN_W*WIN_H)+1 | Active pixels counted since the last clear |

## Verification
The bench sends bursts of full batches to a single row. A design that drops the write-back bypass would keep only every other increment, so the row would read about half its true count. It also reads a row in the very cycle after its last update, where a missing readout bypass returns the stale word. It offers batches in the `clr_go` cycle and throughout the sweep, and measures the sweep length. A design that still accepts those batches, or that runs one cycle short or long, leaves a nonzero row or total, or shows the wrong busy count. All-zero batches and alternating rows check that the enable and the bypass row compare do not disturb unrelated or untouched counts.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int MAX_LANES = 16;

  // Number of active lanes in a batch (upper unused bits must be zero).
  function automatic logic [4:0] lane_sum(input logic [MAX_LANES-1:0] v);
    logic [4:0] s;
    s = '0;
    for (int i = 0; i < MAX_LANES; i++) s = s + {4'd0, v[i]};
    return s;
  endfunction
endpackage

// File: rtl/row_store.sv
module row_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Read-before-write on a shared address; the caller bypasses.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/row_sweep.sv
module row_sweep #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic [AW-1:0] addr
);
  logic last_row;
  assign last_row = (addr == AW'(DEPTH-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        addr <= '0;
      end
    end else if (last_row) begin
      busy <= 1'b0;
    end else begin
      addr <= addr + 1'b1;
    end
  end

  // R6: the sweep starts at row zero and stops after the last row
  p_sweep_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> addr == '0);
  p_sweep_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_row) |=> !busy);
endmodule

// File: rtl/row_hist_accum.sv
module row_hist_accum #(
  parameter int WIN_W = 32,
  parameter int WIN_H = 32,
  parameter int LANES = 4,
  localparam int RAW  = $clog2(WIN_H),
  localparam int CW   = $clog2(WIN_W) + 1,
  localparam int TW   = $clog2(WIN_W * WIN_H) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_go,
  output logic             clr_busy,
  input  logic             pix_valid,
  input  logic [LANES-1:0] pix,
  input  logic [RAW-1:0]   row_idx,
  input  logic [RAW-1:0]   rd_row,
  output logic [CW-1:0]    rd_count,
  output logic [TW-1:0]    total
);
  import hist_pkg::*;

  // Named internal events
  logic           accept;
  logic [4:0]     batch_sum;
  logic [RAW-1:0] rd_addr;
  logic [CW-1:0]  mem_q;
  logic [RAW-1:0] sweep_addr;

  logic           s1_we;
  logic [RAW-1:0] s1_row;
  logic [CW-1:0]  s1_inc;

  logic           fw_v;
  logic [RAW-1:0] fw_row;
  logic [CW-1:0]  fw_data;
  logic           fw_hit;
  logic [CW-1:0]  base;
  logic [CW-1:0]  upd;

  logic           wr_en;
  logic [RAW-1:0] wr_addr;
  logic [CW-1:0]  wr_data;

  assign accept    = pix_valid && !clr_busy && !clr_go;
  assign batch_sum = lane_sum(MAX_LANES'(pix));
  assign rd_addr   = accept ? row_idx : rd_row;

  row_sweep #(.DEPTH(WIN_H)) sweep_i (
    .clk(clk), .rst_n(rst_n), .go(clr_go), .busy(clr_busy), .addr(sweep_addr)
  );

  row_store #(.DEPTH(WIN_H), .DW(CW)) store_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(mem_q)
  );

  // Stage 1: registered address, enable and increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_we  <= 1'b0;
      s1_row <= '0;
      s1_inc <= '0;
    end else begin
      s1_we  <= accept && (|pix);
      s1_row <= rd_addr;
      s1_inc <= accept ? CW'(batch_sum) : '0;
    end
  end

  // Bypass of the word written on the edge that also read it
  assign fw_hit   = fw_v && (fw_row == s1_row);
  assign base     = fw_hit ? fw_data : mem_q;
  assign upd      = base + s1_inc;
  assign rd_count = base;

  assign wr_en   = clr_busy || s1_we;
  assign wr_addr = clr_busy ? sweep_addr : s1_row;
  assign wr_data = clr_busy ? '0 : upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_v    <= 1'b0;
      fw_row  <= '0;
      fw_data <= '0;
    end else begin
      fw_v    <= wr_en;
      fw_row  <= wr_addr;
      fw_data <= wr_data;
    end
  end

  // Window total
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      total <= '0;
    else if (clr_go) total <= '0;
    else if (accept) total <= total + TW'(batch_sum);
  end

  // R7: the clear request zeroes the total
  p_clr_zero_total_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> total == '0);
  // R7: nothing is queued for write while the sweep owns the port
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> !s1_we || !clr_busy);
  // R4: an empty batch leaves the total untouched
  p_zero_batch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !clr_go && !clr_busy && pix == '0) |=> $stable(total));
  // R5: without a clear the total never decreases
  p_total_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_go |=> total >= $past(total));
  // R6: every sweep cycle writes a zero word
  p_clear_write_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> (wr_en && wr_data == '0));
endmodule

// File: tb/row_hist_accum_tb_top.sv
module row_hist_accum_tb_top;
  localparam int W = 32, H = 32, L = 4;
  localparam int RAW = $clog2(H), CW = $clog2(W) + 1, TW = $clog2(W * H) + 1;

  logic clk = 0, rst_n = 0, clr_go = 0, pix_valid = 0;
  logic clr_busy;
  logic [L-1:0] pix = '0;
  logic [RAW-1:0] row_idx = '0, rd_row = '0;
  logic [CW-1:0] rd_count;
  logic [TW-1:0] total;

  int errors = 0, checks = 0;
  int exp_row [H];
  int exp_total = 0;

  always #10 clk = ~clk;

  row_hist_accum #(.WIN_W(W), .WIN_H(H), .LANES(L)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bits(input logic [L-1:0] v);
    int n = 0;
    for (int i = 0; i < L; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic send(input int r, input logic [L-1:0] p);
    pix_valid = 1; row_idx = RAW'(r); pix = p;
    exp_row[r] += bits(p);
    exp_total += bits(p);
    @(negedge clk);
    pix_valid = 0; pix = '0;
  endtask

  task automatic read_row(input int r, output int v);
    pix_valid = 0; rd_row = RAW'(r);
    @(negedge clk);
    v = int'(rd_count);
  endtask

  task automatic check_all_rows(input string req);
    int v;
    for (int r = 0; r < H; r++) begin
      read_row(r, v);
      check(req, v, exp_row[r]);
    end
  endtask

  task automatic do_clear(input string req);
    int n = 0;
    clr_go = 1;
    @(negedge clk);
    clr_go = 0;
    check({req, " total cleared"}, int'(total), 0);
    while (clr_busy && n < 100) begin n++; @(negedge clk); end
    check({req, " busy length"}, n, H);
    for (int r = 0; r < H; r++) exp_row[r] = 0;
    exp_total = 0;
  endtask

  task automatic t_reset;
    check("R1 busy", int'(clr_busy), 0);
    check("R1 total", int'(total), 0);
    do_clear("R6");
    check_all_rows("R6 rows zero");
  endtask

  task automatic t_single;
    int v;
    send(4, 4'b0101);
    check("R5 total after batch", int'(total), exp_total);
    send(9, 4'b1110);
    read_row(4, v); check("R2 row4", v, exp_row[4]);
    read_row(9, v); check("R2 row9", v, exp_row[9]);
    read_row(5, v); check("R2 other row", v, 0);
  endtask

  task automatic t_burst;
    int v;
    for (int i = 0; i < 8; i++) send(3, 4'b1111);
    read_row(3, v); check("R3 burst row3 full", v, 32);
    send(5, 4'b0001); send(5, 4'b0110); send(5, 4'b1011); send(5, 4'b1000);
    read_row(5, v); check("R3 mixed burst row5", v, exp_row[5]);
    for (int i = 0; i < 6; i++) send((i % 2) ? 1 : 2, 4'b0111);
    read_row(1, v); check("R3 alternating row1", v, exp_row[1]);
    read_row(2, v); check("R3 alternating row2", v, exp_row[2]);
    check("R5 total", int'(total), exp_total);
  endtask

  task automatic t_zero;
    int v, t0;
    t0 = int'(total);
    send(9, 4'b0000); send(9, 4'b0000);
    check("R4 total unchanged", int'(total), t0);
    read_row(9, v); check("R4 row unchanged", v, exp_row[9]);
  endtask

  task automatic t_readback_hit;
    int v;
    send(7, 4'b1101);
    read_row(7, v); check("R8 readout same-edge write", v, exp_row[7]);
    send(7, 4'b0011); send(7, 4'b1000);
    read_row(7, v); check("R8 readout after burst", v, exp_row[7]);
    check_all_rows("R8 full readout");
  endtask

  task automatic t_clear_ignore;
    int n = 0;
    clr_go = 1; pix_valid = 1; row_idx = 6; pix = 4'b1111;
    @(negedge clk);
    clr_go = 0;
    check("R7 total zero on clear", int'(total), 0);
    while (clr_busy && n < 100) begin
      row_idx = RAW'(n % H); pix = 4'b1111; pix_valid = 1;
      n++; @(negedge clk);
    end
    pix_valid = 0; pix = '0;
    check("R6 busy length with traffic", n, H);
    check("R7 total after ignored traffic", int'(total), 0);
    for (int r = 0; r < H; r++) exp_row[r] = 0;
    exp_total = 0;
    check_all_rows("R7 rows zero");
    send(0, 4'b1001);
    check("R5 total restarts", int'(total), 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < H; r++) exp_row[r] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_zero();
    t_readback_hit();
    t_clear_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule